// File: doc/BRIEF.md
# Mode-Programmable Program Bank Mapper

This block translates CPU addresses from 0x6000 to 0xFFFF into a physical address in either a banked program ROM or a banked battery-backed work RAM. The range is cut into five 8 KB windows. The window at 0x6000 always shows a work-RAM bank. The four program windows at 0x8000, 0xA000, 0xC000 and 0xE000 each show either a ROM bank or a RAM bank. A separate register-write port programs the mapping, and the translation itself is purely combinational from the CPU address.

A 2-bit size mode selects how the four bank registers are read. The same registers can describe:
- one 32 KB block,
- two 16 KB halves,
- a 16 KB half followed by two 8 KB windows, or
- four independent 8 KB windows.

A mode change does not remap anything on its own. It only decides how later bank-register writes are interpreted. ROM bank numbers are masked to the ROM size, rounded up to a power of two. RAM writes are allowed only while two 2-bit protect registers together hold an unlock pair.

Top module: `pbm_mapper`

## Requirements
- R1: After reset, all four program windows map ROM bank (ROM_BANKS-1) masked per R8. The 0x6000 window maps RAM bank 0. Protect A reads 2 and protect B reads 1, so RAM writes are unlocked. The size mode is 3.
- R2: `reg_addr_i` is the offset from 0x5100. The offsets are:
  - 0x00: size mode, bits [1:0].
  - 0x02: protect A, bits [1:0].
  - 0x03: protect B, bits [1:0].
  - 0x13: RAM bank of the 0x6000 window, bits [2:0].
  - 0x14 to 0x17: bank registers for slots 0 to 3 (0x8000, 0xA000, 0xC000, 0xE000).
  - Writes to any other offset have no effect.
- R3: In mode 0, a slot-3 write with bit 7 set maps windows 0 to 3 to ROM banks (v&0x7C)+0 through +3. All other bank writes are ignored.
- R4: In mode 1, a slot-1 write loads windows 0 and 1 with (v&0x7E)+0 and +1. A slot-3 ROM write loads windows 2 and 3 the same way. Slots 0 and 2 are ignored.
- R5: In mode 2, slot 1 loads the lower 16 KB pair as in R4. Slot 2 loads window 2 alone, and a slot-3 ROM write loads window 3 alone with v&0x7F. Slot 0 is ignored.
- R6: In mode 3, slot k loads window k alone: a ROM bank of v&0x7F, or a RAM bank of v&7 when bit 7 is clear.
- R7: Bit 7 of a bank value set means ROM. Bit 7 clear means RAM, with bank v&7, or (v&6)+0/+1 for a pair. A RAM value written to slot 3, or any RAM value in mode 0, is ignored, so window 0xE000 always maps ROM.
- R8: A ROM bank is ANDed with (P-1), where P is the smallest power of two that is at least ROM_BANKS.
- R9: `mem_we_o` is 1 only when all of these hold: `cpu_wr_i` is 1, the addressed window maps RAM, protect A holds 2 and protect B holds 1. Each protect register keeps only the low 2 bits of the written value.
- R10: Writing the size mode leaves every window's current mapping unchanged.
- R11: For addresses of 0x6000 and above, `hit_o`=1 and `phys_addr_o` = {bank, cpu_addr_i[12:0]}, where a RAM bank sits in the low 3 bank bits and `sel_ram_o`=1 marks RAM. For addresses below 0x6000, `hit_o`, `sel_ram_o`, `mem_we_o` and `phys_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register offset from 0x5100 |
| reg_data_i | input | 8 | Register write data |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wr_i | input | 1 | CPU access is a write |
| hit_o | output | 1 | Address falls in 0x6000 to 0xFFFF |
| sel_ram_o | output | 1 | 1 selects work RAM, 0 selects ROM |
| mem_we_o | output | 1 | Write enable to work RAM |
| phys_addr_o | output | 20 | Physical bank and offset |

## Verification
Each size mode is tried with ROM values, with RAM values, and with values sent to the slots that the mode ignores. This separates a slot that loads a pair from one that loads a single window, and a slot that loads nothing. Bank values with high bits set, such as 0xFF, separate masked from unmasked ROM numbers. Protect values such as 0x06 separate a register that keeps 2 bits from one that keeps the full byte. A long random mix of register writes, probed in every window after each write, checks that mode changes only affect later writes.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int OFF_W  = 13;
  localparam int BANK_W = 7;
  localparam int RAM_W  = 3;
  localparam int SLOTS  = 4;

  localparam logic [4:0] REG_MODE    = 5'h00;
  localparam logic [4:0] REG_PROT_A  = 5'h02;
  localparam logic [4:0] REG_PROT_B  = 5'h03;
  localparam logic [4:0] REG_RAM_WIN = 5'h13;

  localparam logic [1:0] UNLOCK_A = 2'd2;
  localparam logic [1:0] UNLOCK_B = 2'd1;

  typedef enum logic [1:0] {
    SZ_32K = 2'd0,
    SZ_16K = 2'd1,
    SZ_MIX = 2'd2,
    SZ_8K  = 2'd3
  } size_mode_e;

  typedef struct packed {
    logic              is_ram;
    logic [BANK_W-1:0] bank;
  } win_t;

  function automatic logic [BANK_W-1:0] rom_mask_f(int n);
    int p;
    p = 1;
    for (int i = 0; i <= BANK_W; i++) if (p < n) p = p * 2;
    return BANK_W'(p - 1);
  endfunction

  function automatic win_t rom_win(logic [BANK_W-1:0] b);
    win_t w;
    w.is_ram = 1'b0;
    w.bank   = b;
    return w;
  endfunction

  function automatic win_t ram_win(logic [RAM_W-1:0] b);
    win_t w;
    w.is_ram = 1'b1;
    w.bank   = BANK_W'(b);
    return w;
  endfunction
endpackage

// File: rtl/pbm_ctrl_regs.sv
module pbm_ctrl_regs
  import pbm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [RAM_W-1:0] reg_data_i,
  output size_mode_e       mode_o,
  output logic [1:0]       prot_a_o,
  output logic [1:0]       prot_b_o,
  output logic [RAM_W-1:0] ram_win_o,
  output logic             slot_we_o,
  output logic [1:0]       slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= SZ_8K;
      prot_a_o  <= UNLOCK_A;
      prot_b_o  <= UNLOCK_B;
      ram_win_o <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_MODE:    mode_o    <= size_mode_e'(reg_data_i[1:0]);
        REG_PROT_A:  prot_a_o  <= reg_data_i[1:0];
        REG_PROT_B:  prot_b_o  <= reg_data_i[1:0];
        REG_RAM_WIN: ram_win_o <= reg_data_i;
        default: ;
      endcase
    end
  end

  // offsets 0x14..0x17 carry the slot bank registers
  assign slot_we_o = reg_we_i && (reg_addr_i[4:2] == 3'b101);
  assign slot_o    = reg_addr_i[1:0];
endmodule

// File: rtl/pbm_slot_decode.sv
module pbm_slot_decode
  import pbm_pkg::*;
(
  input  size_mode_e       mode_i,
  input  logic             slot_we_i,
  input  logic [1:0]       slot_i,
  input  logic [7:0]       data_i,
  output logic [SLOTS-1:0] upd_o,
  output win_t [SLOTS-1:0] nxt_o
);
  logic              is_rom;
  logic [BANK_W-1:0] v8, v16, v32;
  logic [RAM_W-1:0]  r8, r16;

  always_comb begin
    is_rom = data_i[7];
    v8     = data_i[6:0];
    v16    = {data_i[6:1], 1'b0};
    v32    = {data_i[6:2], 2'b00};
    r8     = data_i[2:0];
    r16    = {data_i[2:1], 1'b0};
    upd_o  = '0;
    nxt_o  = '0;
    if (slot_we_i) begin
      unique case (mode_i)
        SZ_32K: begin
          if (slot_i == 2'd3 && is_rom)
            for (int i = 0; i < SLOTS; i++) begin
              upd_o[i] = 1'b1;
              nxt_o[i] = rom_win(v32 | BANK_W'(i));
            end
        end
        SZ_16K, SZ_MIX: begin
          if (slot_i == 2'd1) begin
            for (int i = 0; i < 2; i++) begin
              upd_o[i] = 1'b1;
              nxt_o[i] = is_rom ? rom_win(v16 | BANK_W'(i)) : ram_win(r16 | RAM_W'(i));
            end
          end else if (mode_i == SZ_16K) begin
            if (slot_i == 2'd3 && is_rom)
              for (int i = 2; i < 4; i++) begin
                upd_o[i] = 1'b1;
                nxt_o[i] = rom_win(v16 | BANK_W'(i - 2));
              end
          end else if (slot_i == 2'd2) begin
            upd_o[2] = 1'b1;
            nxt_o[2] = is_rom ? rom_win(v8) : ram_win(r8);
          end else if (slot_i == 2'd3 && is_rom) begin
            upd_o[3] = 1'b1;
            nxt_o[3] = rom_win(v8);
          end
        end
        SZ_8K: begin
          if (slot_i != 2'd3 || is_rom) begin
            upd_o[slot_i] = 1'b1;
            nxt_o[slot_i] = is_rom ? rom_win(v8) : ram_win(r8);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pbm_window_file.sv
module pbm_window_file
  import pbm_pkg::*;
#(
  parameter logic [BANK_W-1:0] RESET_BANK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] upd_i,
  input  win_t [SLOTS-1:0] nxt_i,
  output win_t [SLOTS-1:0] win_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       win_o[g] <= rom_win(RESET_BANK);
      else if (upd_i[g]) win_o[g] <= nxt_i[g];
    end
  end
endmodule

// File: rtl/pbm_xlate.sv
module pbm_xlate
  import pbm_pkg::*;
#(
  parameter logic [BANK_W-1:0] ROM_MASK = '1,
  localparam int PHYS_W = BANK_W + OFF_W
) (
  input  logic [15:0]       cpu_addr_i,
  input  logic              cpu_wr_i,
  input  win_t [SLOTS-1:0]  win_i,
  input  logic [RAM_W-1:0]  ram_win_i,
  input  logic [1:0]        prot_a_i,
  input  logic [1:0]        prot_b_i,
  output logic              hit_o,
  output logic              sel_ram_o,
  output logic              mem_we_o,
  output logic [PHYS_W-1:0] phys_addr_o
);
  logic [2:0]        region;
  win_t              cur;
  logic [BANK_W-1:0] bank;
  logic              unlocked;

  always_comb begin
    region   = cpu_addr_i[15:13];
    hit_o    = region >= 3'd3;
    cur      = (region == 3'd3) ? ram_win(ram_win_i) : win_i[region[1:0]];
    bank     = cur.is_ram ? {{(BANK_W-RAM_W){1'b0}}, cur.bank[RAM_W-1:0]}
                          : (cur.bank & ROM_MASK);
    unlocked = (prot_a_i == UNLOCK_A) && (prot_b_i == UNLOCK_B);
    if (hit_o) begin
      sel_ram_o   = cur.is_ram;
      phys_addr_o = {bank, cpu_addr_i[OFF_W-1:0]};
    end else begin
      sel_ram_o   = 1'b0;
      phys_addr_o = '0;
    end
    mem_we_o = hit_o && cur.is_ram && cpu_wr_i && unlocked;
  end
endmodule

// File: rtl/pbm_mapper.sv
module pbm_mapper
  import pbm_pkg::*;
#(
  parameter int ROM_BANKS = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [4:0]              reg_addr_i,
  input  logic [7:0]              reg_data_i,
  input  logic [15:0]             cpu_addr_i,
  input  logic                    cpu_wr_i,
  output logic                    hit_o,
  output logic                    sel_ram_o,
  output logic                    mem_we_o,
  output logic [BANK_W+OFF_W-1:0] phys_addr_o
);
  localparam logic [BANK_W-1:0] ROM_MASK   = rom_mask_f(ROM_BANKS);
  localparam logic [BANK_W-1:0] RESET_BANK = BANK_W'(ROM_BANKS - 1) & ROM_MASK;

  size_mode_e       mode_q;
  logic [1:0]       prot_a_q, prot_b_q;
  logic [RAM_W-1:0] ram_win_q;
  logic             slot_we;
  logic [1:0]       slot;
  logic [SLOTS-1:0] upd;
  win_t [SLOTS-1:0] nxt, win_q;
  logic [SLOTS-1:0] win_ram_q;

  pbm_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_data_i (reg_data_i[RAM_W-1:0]),
    .mode_o     (mode_q),
    .prot_a_o   (prot_a_q),
    .prot_b_o   (prot_b_q),
    .ram_win_o  (ram_win_q),
    .slot_we_o  (slot_we),
    .slot_o     (slot)
  );

  pbm_slot_decode u_dec (
    .mode_i    (mode_q),
    .slot_we_i (slot_we),
    .slot_i    (slot),
    .data_i    (reg_data_i),
    .upd_o     (upd),
    .nxt_o     (nxt)
  );

  pbm_window_file #(.RESET_BANK(RESET_BANK)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .nxt_i  (nxt),
    .win_o  (win_q)
  );

  pbm_xlate #(.ROM_MASK(ROM_MASK)) u_xl (
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wr_i    (cpu_wr_i),
    .win_i       (win_q),
    .ram_win_i   (ram_win_q),
    .prot_a_i    (prot_a_q),
    .prot_b_i    (prot_b_q),
    .hit_o       (hit_o),
    .sel_ram_o   (sel_ram_o),
    .mem_we_o    (mem_we_o),
    .phys_addr_o (phys_addr_o)
  );

  always_comb
    for (int i = 0; i < SLOTS; i++) win_ram_q[i] = win_q[i].is_ram;
endmodule

// File: rtl/pbm_mapper_chk.sv
module pbm_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [4:0]  reg_addr_i,
  input logic [7:0]  reg_data_i,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_wr_i,
  input logic        hit_o,
  input logic        sel_ram_o,
  input logic        mem_we_o,
  input logic [1:0]  mode_q,
  input logic [1:0]  prot_a_q,
  input logic [1:0]  prot_b_q,
  input logic [3:0]  win_ram_q
);
  assert_mode_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 5'h00 |=> mode_q == $past(reg_data_i[1:0]));

  assert_prot_a_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 5'h02 |=> prot_a_q == $past(reg_data_i[1:0]));

  assert_prot_b_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 5'h03 |=> prot_b_q == $past(reg_data_i[1:0]));

  assert_we_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> sel_ram_o && cpu_wr_i && prot_a_q == 2'd2 && prot_b_q == 2'd1);

  assert_top_rom_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:13] == 3'd7 |-> !sel_ram_o && !win_ram_q[3]);

  assert_mode_no_remap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 5'h00 |=> $stable(win_ram_q));

  assert_low_miss_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i < 16'h6000 |-> !hit_o && !sel_ram_o && !mem_we_o);

  assert_ram_window_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:13] == 3'd3 |-> hit_o && sel_ram_o);
endmodule

bind pbm_mapper pbm_mapper_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_data_i (reg_data_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_wr_i   (cpu_wr_i),
  .hit_o      (hit_o),
  .sel_ram_o  (sel_ram_o),
  .mem_we_o   (mem_we_o),
  .mode_q     (mode_q),
  .prot_a_q   (prot_a_q),
  .prot_b_q   (prot_b_q),
  .win_ram_q  (win_ram_q)
);

// File: tb/tb_pbm_mapper.sv
`timescale 1ns/1ps
module tb_pbm_mapper;
  localparam int ROM_BANKS = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [7:0]  reg_data_i = '0;
  logic [15:0] cpu_addr_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic        hit_o, sel_ram_o, mem_we_o;
  logic [19:0] phys_addr_o;

  always #2 clk_i = ~clk_i;

  pbm_mapper #(.ROM_BANKS(ROM_BANKS)) dut (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  int  m_mode, m_pa, m_pb, m_r0, m_mask;
  bit  m_ram [4];
  int  m_bank [4];

  function automatic void set_win(int w, bit ram, int b);
    m_ram[w]  = ram;
    m_bank[w] = b;
  endfunction

  function automatic void model_reset();
    int p = 1;
    while (p < ROM_BANKS) p = p * 2;
    m_mask = p - 1;
    m_mode = 3; m_pa = 2; m_pb = 1; m_r0 = 0;
    for (int w = 0; w < 4; w++) set_win(w, 0, (ROM_BANKS - 1) & m_mask);
  endfunction

  function automatic void model_write(int off, int d);
    bit rom = d >= 128;
    int s;
    if (off == 0) m_mode = d % 4;
    else if (off == 2) m_pa = d % 4;
    else if (off == 3) m_pb = d % 4;
    else if (off == 'h13) m_r0 = d % 8;
    else if (off >= 'h14 && off <= 'h17) begin
      s = off - 'h14;
      if (s == 3 && !rom) return;
      if (m_mode == 0) begin
        if (s == 3) for (int k = 0; k < 4; k++) set_win(k, 0, (d / 4 % 32) * 4 + k);
      end else if (m_mode == 3) begin
        if (rom) set_win(s, 0, d % 128); else set_win(s, 1, d % 8);
      end else if (s == 1) begin
        for (int k = 0; k < 2; k++)
          if (rom) set_win(k, 0, (d / 2 % 64) * 2 + k);
          else set_win(k, 1, (d / 2 % 4) * 2 + k);
      end else if (m_mode == 1 && s == 3) begin
        set_win(2, 0, (d / 2 % 64) * 2);
        set_win(3, 0, (d / 2 % 64) * 2 + 1);
      end else if (m_mode == 2 && s >= 2) begin
        if (rom) set_win(s, 0, d % 128); else set_win(s, 1, d % 8);
      end
    end
  endfunction

  task automatic wr(input int off, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 5'(off); reg_data_i = 8'(d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
    model_write(off, d);
  endtask

  task automatic probe(input int a, input bit w, input string tag);
    int ex_hit, ex_sel, ex_we, ex_phys, b, win;
    cpu_addr_i = 16'(a); cpu_wr_i = w;
    #0.5;
    if (a < 'h6000) begin
      ex_hit = 0; ex_sel = 0; ex_we = 0; ex_phys = 0;
    end else begin
      ex_hit = 1;
      if (a < 'h8000) begin ex_sel = 1; b = m_r0; end
      else begin
        win = (a - 'h8000) / 'h2000;
        ex_sel = m_ram[win];
        b = ex_sel ? m_bank[win] : (m_bank[win] & m_mask);
      end
      ex_phys = b * 'h2000 + (a % 'h2000);
      ex_we = (w && ex_sel && m_pa == 2 && m_pb == 1) ? 1 : 0;
    end
    n_checks++;
    if (hit_o !== 1'(ex_hit) || sel_ram_o !== 1'(ex_sel) || mem_we_o !== 1'(ex_we) ||
        phys_addr_o !== 20'(ex_phys)) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0d: got hit=%b sel=%b we=%b phys=%h, exp hit=%0d sel=%0d we=%0d phys=%h",
               tag, a, w, hit_o, sel_ram_o, mem_we_o, phys_addr_o, ex_hit, ex_sel, ex_we, ex_phys);
    end
  endtask

  task automatic sweep(input string tag);
    for (int r = 3; r < 8; r++) probe(r * 'h2000 + ($urandom % 'h2000), 1'($urandom), tag);
    probe($urandom % 'h6000, 1'b1, "R11");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int offs [10] = '{0, 2, 3, 'h13, 'h14, 'h15, 'h16, 'h17, 'h10, 'h1f};
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset mapping, unlocked RAM at 0x6000
    probe('h8000, 1, "R1"); probe('hE123, 1, "R1"); probe('h6010, 1, "R1");
    probe('h0000, 1, "R11"); probe('h5FFF, 1, "R11");
    // R6 / R7 / R8 in mode 3
    wr('h14, 'h85); wr('h15, 'h03); wr('h16, 'hFF); wr('h17, 'h03);
    sweep("R6"); probe('hC000, 0, "R8"); probe('hE000, 1, "R7");
    // R10 mode change keeps mapping, R3 mode 0
    wr(0, 'h00); sweep("R10");
    wr('h14, 'h90); sweep("R3");
    wr('h17, 'h8B); sweep("R3");
    wr('h17, 'h05); probe('hE000, 1, "R7"); sweep("R7");
    // R4 mode 1
    wr(0, 'h01); wr('h15, 'h83); sweep("R4");
    wr('h17, 'h8F); sweep("R4");
    wr('h15, 'h05); sweep("R4"); probe('hA000, 1, "R7");
    wr('h14, 'h81); wr('h16, 'h81); sweep("R4");
    // R5 mode 2
    wr(0, 'h02); wr('h15, 'h97); sweep("R5");
    wr('h16, 'h02); sweep("R5");
    wr('h17, 'h99); sweep("R5");
    wr('h16, 'h84); wr('h14, 'h82); sweep("R5");
    // R2 register map
    wr('h13, 'hFD); probe('h6ABC, 1, "R2");
    wr('h10, 'h77); wr('h1F, 'h55); wr('h01, 'h00); sweep("R2");
    // R9 protect storage and unlock pair
    wr(0, 'h03); wr('h14, 'h01);
    wr(2, 'h06); probe('h8000, 1, "R9"); probe('h6000, 1, "R9");
    wr(3, 'h00); probe('h8000, 1, "R9"); probe('h6000, 1, "R9");
    wr(3, 'h05); probe('h6000, 1, "R9"); probe('h6000, 0, "R9");
    wr(2, 'h03); probe('h6000, 1, "R9");
    wr(2, 'h02); probe('h9FFF, 1, "R9"); probe('hA000, 1, "R9");
    // random mix
    for (int i = 0; i < 400; i++) begin
      wr(offs[$urandom % 10], $urandom % 256);
      sweep("R11");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule